// File: doc/BRIEF.md
# Oversampled Type B Frame Receiver

This block deframes the downlink bit stream of a proximity card link, the direction from the reader to the card. It takes a one-bit sample stream with a qualifying strobe, at four samples per bit time. First it finds the long low start-of-frame period and checks its length. It then recovers 10-bit characters, each made of a low start bit, eight data bits sent least significant first and a high stop bit. Every valid data byte comes out with a one-cycle strobe. An all-zero character closes the frame, and the block then pulses a completion strobe that carries the byte count.

Every error has the same effect: the block drops back to its unsynchronised state and reports nothing for the broken frame. The errors are a start-of-frame low period of the wrong length, a line that stays high too long while a start bit is due, a character with bad framing, and a frame longer than the limit. An `active` output shows that the block has locked onto a frame. A sniffer can use it to mute the decoder for the opposite direction. An asynchronous active-low reset and a synchronous soft clear both return the block to idle.

Top module: `pcd_frame_rx`

## Requirements
- R1: After `rst_n` is released, and in the cycle after `soft_clr` is sampled high, `active`, `byte_vld` and `frame_done` are all 0. A partly received frame is dropped.
- R2: Only clock cycles with `sample_vld` high advance the receiver. Within a bit time of OSR=4 samples, the bit value is taken from the third sample, counting from the falling edge that started the character. The values of the other three samples are ignored.
- R3: A start of frame is a run of zero bits that begins at a falling edge in the unsynchronised state, followed by a high mid-bit sample. It is accepted only if it has between 10 and 12 zero bits. A run of 9 or fewer zero bits is rejected, and the following characters produce no output.
- R4: When a thirteenth consecutive zero bit is sampled during the start of frame, the frame is abandoned.
- R5: While a start bit is awaited, the line may stay high for up to 25 samples. On the 26th high sample the frame is abandoned. A falling edge on or before the 25th high sample starts a character.
- R6: In a character, the first bit received is the start bit (0) and the tenth is the stop bit (1). The eight bits between them form `byte_data`, least significant bit first. `byte_data` is shown together with a one-cycle `byte_vld` pulse.
- R7: An all-zero 10-bit character ends the frame. If at least one byte was received, `frame_done` pulses for one cycle and `frame_len` equals the number of data bytes in the frame.
- R8: An all-zero character that arrives before any data byte ends the frame with no `frame_done` pulse.
- R9: A character that is neither a valid data character nor all zeros (for example, stop bit 0 with a nonzero payload) abandons the frame. It produces no `byte_vld`, and no `frame_done` follows.
- R10: A frame holds at most MAX_BYTES data bytes. A data character that arrives when MAX_BYTES bytes have already been received is not output, and the frame is abandoned without `frame_done`.
- R11: `active` is 1 from an accepted start of frame until the end or abandonment of the frame. It is 0 in the cycle in which `frame_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear back to idle |
| sample_vld | input | 1 | Qualifies `sample_bit` for this cycle |
| sample_bit | input | 1 | Oversampled line level |
| byte_vld | output | 1 | One-cycle strobe for a received data byte |
| byte_data | output | DATA_W (8) | Received data byte |
| frame_done | output | 1 | One-cycle strobe at a good end of frame |
| frame_len | output | $clog2(MAX_BYTES+1) | Byte count of the completed frame |
| active | output | 1 | Receiver is locked onto a frame |

## Verification
The bench builds the receiver with MAX_BYTES set to 4, so that a frame filled exactly to the limit and a frame one byte over it are both only a few characters long. The other parameters keep their defaults: four samples per bit, a start-of-frame window of 10 to 12 zero bits, and a 25-sample wait for a start bit. With these values the tests can place stimulus at the exact edges of each window: 9, 10, 12 and 13 zero bits, and 25 against 26 high samples. Every sample is followed by cycles in which `sample_vld` is low and the line carries the opposite level. The data bits of one frame also have inverted values on every sample except the third of each bit.

// File: rtl/pcd_rx_pkg.sv
package pcd_rx_pkg;

  typedef enum logic [1:0] {
    ST_UNSYNC = 2'd0,
    ST_SOF    = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RECV   = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    CK_DATA = 2'd0,
    CK_EOF  = 2'd1,
    CK_BAD  = 2'd2
  } char_kind_e;

endpackage

// File: rtl/pcd_rx_shift.sv
module pcd_rx_shift
  import pcd_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHAR_N = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data,
  output char_kind_e        kind
);

  logic [CHAR_N-1:0] sr_q;
  logic [CHAR_N-1:0] sr_d;

  // new bits enter at the top and travel down, so the first bit ends at bit 0
  always_comb begin
    sr_d = sr_q;
    if (clr)     sr_d = '0;
    else if (en) sr_d = {bit_in, sr_q[CHAR_N-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  always_comb begin
    if (sr_q == '0)                      kind = CK_EOF;
    else if (sr_q[CHAR_N-1] && !sr_q[0]) kind = CK_DATA;
    else                                 kind = CK_BAD;
  end

  assign data = sr_q[CHAR_N-2:1];

endmodule

// File: rtl/pcd_rx_count.sv
module pcd_rx_count #(
  parameter int MAX_BYTES = 256,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [LEN_W-1:0] count,
  output logic             zero,
  output logic             full
);

  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_BYTES);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);
  assign full  = (cnt_q == LIMIT);

endmodule

// File: rtl/pcd_rx_seq.sv
module pcd_rx_seq
  import pcd_rx_pkg::*;
#(
  parameter int OSR          = 4,
  parameter int SOF_MIN_BITS = 10,
  parameter int SOF_MAX_BITS = 12,
  parameter int GAP_MAX      = 25,
  parameter int CHAR_N       = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       smp_vld,
  input  logic       smp_bit,
  input  char_kind_e kind,
  input  logic       cnt_zero,
  input  logic       cnt_full,
  output rx_state_e  state,
  output logic       sh_clr,
  output logic       sh_en,
  output logic       cnt_clr,
  output logic       cnt_inc,
  output logic       emit_byte,
  output logic       emit_done
);

  localparam int PH_W    = $clog2(OSR + 1);
  localparam int BIT_LIM = (SOF_MAX_BITS + 1 > CHAR_N) ? SOF_MAX_BITS + 1 : CHAR_N;
  localparam int BIT_W   = $clog2(BIT_LIM + 1);
  localparam int GAP_W   = $clog2(GAP_MAX + 2);

  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(OSR / 2);
  localparam logic [PH_W-1:0]  PH_WRAP   = PH_W'(OSR);
  localparam logic [BIT_W-1:0] SOF_MIN   = BIT_W'(SOF_MIN_BITS);
  localparam logic [BIT_W-1:0] SOF_MAX   = BIT_W'(SOF_MAX_BITS);
  localparam logic [BIT_W-1:0] CHAR_END  = BIT_W'(CHAR_N);
  localparam logic [GAP_W-1:0] GAP_LIM   = GAP_W'(GAP_MAX);

  rx_state_e        state_q, state_d;
  logic [PH_W-1:0]  ph_q, ph_d, ph_inc;
  logic [BIT_W-1:0] bit_q, bit_d, bit_inc;
  logic [GAP_W-1:0] gap_q, gap_d, gap_inc;

  always_comb begin
    state_d   = state_q;
    ph_d      = ph_q;
    bit_d     = bit_q;
    gap_d     = gap_q;
    sh_clr    = 1'b0;
    sh_en     = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    emit_byte = 1'b0;
    emit_done = 1'b0;
    ph_inc    = ph_q + PH_W'(1);
    bit_inc   = bit_q + BIT_W'(1);
    gap_inc   = gap_q + GAP_W'(1);

    if (smp_vld) begin
      unique case (state_q)
        ST_UNSYNC: begin
          if (!smp_bit) begin
            state_d = ST_SOF;
            ph_d    = '0;
            bit_d   = '0;
            cnt_clr = 1'b1;
          end
        end
        ST_SOF: begin
          ph_d = (ph_inc == PH_WRAP) ? '0 : ph_inc;
          if (ph_inc == PH_SAMPLE) begin
            if (smp_bit) begin
              if (bit_q >= SOF_MIN) begin
                state_d = ST_WAIT;
                gap_d   = '0;
              end else begin
                state_d = ST_UNSYNC;
              end
            end else begin
              bit_d = bit_inc;
              if (bit_inc > SOF_MAX) state_d = ST_UNSYNC;
            end
          end
        end
        ST_WAIT: begin
          if (smp_bit) begin
            gap_d = gap_inc;
            if (gap_inc > GAP_LIM) state_d = ST_UNSYNC;
          end else begin
            state_d = ST_RECV;
            ph_d    = '0;
            bit_d   = '0;
            sh_clr  = 1'b1;
          end
        end
        ST_RECV: begin
          ph_d = ph_inc;
          if (ph_inc == PH_SAMPLE) sh_en = 1'b1;
          if (ph_inc == PH_WRAP) begin
            ph_d  = '0;
            bit_d = bit_inc;
            if (bit_inc == CHAR_END) begin
              state_d = ST_UNSYNC;
              unique case (kind)
                CK_DATA: begin
                  if (!cnt_full) begin
                    emit_byte = 1'b1;
                    cnt_inc   = 1'b1;
                    state_d   = ST_WAIT;
                    gap_d     = '0;
                  end
                end
                CK_EOF:  emit_done = !cnt_zero;
                default: emit_done = 1'b0;
              endcase
            end
          end
        end
        default: state_d = ST_UNSYNC;
      endcase
    end

    if (soft_clr) begin
      state_d   = ST_UNSYNC;
      ph_d      = '0;
      bit_d     = '0;
      gap_d     = '0;
      sh_clr    = 1'b1;
      sh_en     = 1'b0;
      cnt_clr   = 1'b1;
      cnt_inc   = 1'b0;
      emit_byte = 1'b0;
      emit_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNSYNC;
      ph_q    <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      gap_q   <= gap_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/pcd_frame_rx.sv
module pcd_frame_rx
  import pcd_rx_pkg::*;
#(
  parameter int OSR          = 4,
  parameter int SOF_MIN_BITS = 10,
  parameter int SOF_MAX_BITS = 12,
  parameter int GAP_MAX      = 25,
  parameter int DATA_W       = 8,
  parameter int MAX_BYTES    = 256,
  localparam int LEN_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              sample_vld,
  input  logic              sample_bit,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_data,
  output logic              frame_done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              active
);

  localparam int CHAR_N = DATA_W + 2;

  rx_state_e         state;
  char_kind_e        kind;
  logic [DATA_W-1:0] sh_data;
  logic [LEN_W-1:0]  count;
  logic              cnt_zero, cnt_full;
  logic              sh_clr, sh_en, cnt_clr, cnt_inc, emit_byte, emit_done;

  pcd_rx_seq #(
    .OSR          (OSR),
    .SOF_MIN_BITS (SOF_MIN_BITS),
    .SOF_MAX_BITS (SOF_MAX_BITS),
    .GAP_MAX      (GAP_MAX),
    .CHAR_N       (CHAR_N)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .smp_vld   (sample_vld),
    .smp_bit   (sample_bit),
    .kind      (kind),
    .cnt_zero  (cnt_zero),
    .cnt_full  (cnt_full),
    .state     (state),
    .sh_clr    (sh_clr),
    .sh_en     (sh_en),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .emit_byte (emit_byte),
    .emit_done (emit_done)
  );

  pcd_rx_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sh_clr),
    .en     (sh_en),
    .bit_in (sample_bit),
    .data   (sh_data),
    .kind   (kind)
  );

  pcd_rx_count #(
    .MAX_BYTES (MAX_BYTES)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (count),
    .zero  (cnt_zero),
    .full  (cnt_full)
  );

  logic              bvld_q, done_q;
  logic [DATA_W-1:0] bdat_q;
  logic [LEN_W-1:0]  len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvld_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      bvld_q <= emit_byte;
      done_q <= emit_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bdat_q <= '0;
    else if (emit_byte) bdat_q <= sh_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         len_q <= '0;
    else if (emit_done) len_q <= count;
  end

  assign byte_vld   = bvld_q;
  assign byte_data  = bdat_q;
  assign frame_done = done_q;
  assign frame_len  = len_q;
  assign active     = (state == ST_WAIT) || (state == ST_RECV);

endmodule

// File: rtl/pcd_frame_rx_chk.sv
module pcd_frame_rx_chk #(
  parameter int MAX_BYTES = 256,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr,
  input logic             sample_vld,
  input logic             byte_vld,
  input logic             frame_done,
  input logic [LEN_W-1:0] frame_len,
  input logic             active
);

  assert_clear_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!active && !byte_vld && !frame_done));

  assert_hold_no_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && !soft_clr) |=> (!byte_vld && !frame_done && $stable(active)));

  assert_byte_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> active);

  assert_single_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && frame_done));

  assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len != '0));

  assert_len_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len <= LEN_W'(MAX_BYTES)));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !active);

endmodule

bind pcd_frame_rx pcd_frame_rx_chk #(
  .MAX_BYTES (MAX_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_clr   (soft_clr),
  .sample_vld (sample_vld),
  .byte_vld   (byte_vld),
  .frame_done (frame_done),
  .frame_len  (frame_len),
  .active     (active)
);

// File: tb/tb_pcd_frame_rx.sv
module tb_pcd_frame_rx;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 4;
  localparam int LW         = $clog2(MAXB + 1);

  logic          clk;
  logic          rst_n;
  logic          soft_clr;
  logic          sample_vld;
  logic          sample_bit;
  logic          byte_vld;
  logic [7:0]    byte_data;
  logic          frame_done;
  logic [LW-1:0] frame_len;
  logic          active;

  int checks;
  int errors;
  int junk;
  logic [7:0] cap_bytes [32];
  int cap_n;
  int done_n;
  int last_len;

  pcd_frame_rx #(.MAX_BYTES(MAXB)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_clr),
    .sample_vld (sample_vld),
    .sample_bit (sample_bit),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .frame_done (frame_done),
    .frame_len  (frame_len),
    .active     (active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && byte_vld) begin
      if (cap_n < 32) cap_bytes[cap_n] = byte_data;
      cap_n = cap_n + 1;
    end
    if (rst_n && frame_done) begin
      done_n   = done_n + 1;
      last_len = int'(frame_len);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    summary();
  end

  task automatic chk(string req, int actual, int expected);
    checks = checks + 1;
    if (actual != expected) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic clear_cap();
    cap_n    = 0;
    done_n   = 0;
    last_len = -1;
  endtask

  // one qualified sample, then an idle cycle carrying the opposite level
  task automatic send_samp(logic b);
    @(negedge clk);
    sample_vld = 1'b1;
    sample_bit = b;
    @(negedge clk);
    sample_vld = 1'b0;
    sample_bit = ~b;
  endtask

  task automatic send_bit(logic b);
    for (int i = 0; i < 4; i++) send_samp(b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send_samp(1'b1);
  endtask

  task automatic send_sof(int zbits);
    for (int i = 0; i < zbits; i++) send_bit(1'b0);
    idle(8);
  endtask

  task automatic send_char(logic [7:0] d, logic stop_b, int guard);
    send_bit(1'b0);
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 4; p++) begin
        if (junk != 0 && p != 2) send_samp(~d[k]);
        else                     send_samp(d[k]);
      end
    end
    send_bit(stop_b);
    idle(guard);
  endtask

  task automatic send_eof();
    for (int i = 0; i < 10; i++) send_bit(1'b0);
    idle(4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset byte_vld", int'(byte_vld), 0);
    chk("R1 reset frame_done", int'(frame_done), 0);
    chk("R1 reset active", int'(active), 0);
  endtask

  task automatic t_basic();
    clear_cap();
    idle(6);
    send_sof(10);
    chk("R11 active after SOF", int'(active), 1);
    send_char(8'h05, 1'b1, 4);
    send_char(8'h00, 1'b1, 4);
    send_char(8'hA5, 1'b1, 4);
    send_eof();
    chk("R6 byte count", cap_n, 3);
    chk("R6 byte0", int'(cap_bytes[0]), 'h05);
    chk("R6 byte1", int'(cap_bytes[1]), 'h00);
    chk("R6 byte2", int'(cap_bytes[2]), 'hA5);
    chk("R7 done pulses", done_n, 1);
    chk("R7 frame_len", last_len, 3);
    chk("R11 active after EOF", int'(active), 0);
  endtask

  task automatic t_phase_junk();
    clear_cap();
    junk = 1;
    idle(6);
    send_sof(11);
    send_char(8'h3C, 1'b1, 4);
    send_char(8'hC3, 1'b1, 4);
    send_eof();
    junk = 0;
    chk("R2 byte count", cap_n, 2);
    chk("R2 byte0", int'(cap_bytes[0]), 'h3C);
    chk("R2 byte1", int'(cap_bytes[1]), 'hC3);
    chk("R2 frame_len", last_len, 2);
  endtask

  task automatic t_sof_bounds();
    clear_cap();
    idle(6);
    send_sof(9);
    chk("R3 short SOF active", int'(active), 0);
    send_char(8'h55, 1'b1, 4);
    send_eof();
    idle(40);
    chk("R3 short SOF bytes", cap_n, 0);
    chk("R3 short SOF done", done_n, 0);
    clear_cap();
    send_sof(12);
    send_char(8'h9E, 1'b1, 4);
    send_eof();
    chk("R3 12-bit SOF byte", int'(cap_bytes[0]), 'h9E);
    chk("R3 12-bit SOF len", last_len, 1);
  endtask

  task automatic t_sof_long();
    clear_cap();
    idle(6);
    send_sof(13);
    chk("R4 long SOF active", int'(active), 0);
    send_char(8'hFF, 1'b1, 4);
    send_eof();
    idle(40);
    chk("R4 long SOF bytes", cap_n, 0);
    chk("R4 long SOF done", done_n, 0);
  endtask

  task automatic t_gap();
    clear_cap();
    idle(6);
    send_sof(10);
    send_char(8'h11, 1'b1, 26);
    send_char(8'h22, 1'b1, 4);
    send_eof();
    chk("R5 gap 25 bytes", cap_n, 2);
    chk("R5 gap 25 byte1", int'(cap_bytes[1]), 'h22);
    chk("R5 gap 25 len", last_len, 2);
    clear_cap();
    send_sof(10);
    send_char(8'h33, 1'b1, 27);
    chk("R5 gap 26 active", int'(active), 0);
    send_char(8'hFF, 1'b1, 4);
    send_eof();
    idle(40);
    chk("R5 gap 26 bytes", cap_n, 1);
    chk("R5 gap 26 done", done_n, 0);
  endtask

  task automatic t_empty();
    clear_cap();
    idle(6);
    send_sof(10);
    send_eof();
    chk("R8 empty frame done", done_n, 0);
    chk("R8 empty frame active", int'(active), 0);
  endtask

  task automatic t_framing();
    clear_cap();
    idle(6);
    send_sof(10);
    send_char(8'h12, 1'b1, 4);
    send_char(8'h34, 1'b0, 4);
    chk("R9 bad char active", int'(active), 0);
    send_eof();
    idle(40);
    chk("R9 bytes", cap_n, 1);
    chk("R9 done", done_n, 0);
  endtask

  task automatic t_overflow();
    clear_cap();
    idle(6);
    send_sof(10);
    for (int i = 0; i < MAXB; i++) send_char(8'(8'h40 + i), 1'b1, 4);
    send_eof();
    chk("R10 full frame len", last_len, MAXB);
    chk("R10 full frame bytes", cap_n, MAXB);
    clear_cap();
    send_sof(10);
    for (int i = 0; i <= MAXB; i++) send_char(8'(8'h60 + i), 1'b1, 4);
    chk("R10 overflow active", int'(active), 0);
    send_eof();
    idle(40);
    chk("R10 overflow bytes", cap_n, MAXB);
    chk("R10 overflow done", done_n, 0);
  endtask

  task automatic t_soft_clr();
    clear_cap();
    idle(6);
    send_sof(10);
    send_char(8'h77, 1'b1, 4);
    @(negedge clk);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    chk("R1 soft clear active", int'(active), 0);
    send_char(8'h88, 1'b1, 4);
    send_eof();
    idle(40);
    chk("R1 soft clear bytes", cap_n, 1);
    chk("R1 soft clear done", done_n, 0);
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    junk       = 0;
    rst_n      = 1'b0;
    soft_clr   = 1'b0;
    sample_vld = 1'b0;
    sample_bit = 1'b1;
    clear_cap();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_phase_junk();
    t_sof_bounds();
    t_sof_long();
    t_gap();
    t_empty();
    t_framing();
    t_overflow();
    t_soft_clr();
    repeat (4) @(negedge clk);
    summary();
  end

endmodule